// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. Each cycle in which the enable strobe is high, it takes an operation code, the accumulator value, a second operand and an incoming carry. It computes an 8-bit result and a new set of five status flags: sign, zero, nibble carry, even parity and carry. A write-back enable tells the surrounding register file whether to store the result. The operations are:

- add, with and without carry;
- subtract, with and without borrow;
- compare;
- increment and decrement of the second operand;
- AND, OR and XOR;
- accumulator complement;
- four single-bit rotates.

Each operation updates only the flags it is defined to touch. Every other flag keeps the value held in the block's flag register.

Result, write-back enable and flags are all registered, so they appear one clock after the strobe. The carry consumed by add-with-carry, subtract-with-borrow and the rotate-through-carry forms comes from the `carry_in` port. It is normally fed back from the carry bit of `flags_o`. Increment and decrement act on the second operand, so any register can be stepped. Their write-back goes to whichever register supplied that operand.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `result_o`, `wr_en_o` and `flags_o` are all zero.
- R2: Outputs change one clock after a cycle with `op_valid` high. When `op_valid` is low, `wr_en_o` is 0 on the next clock, and `result_o` and `flags_o` hold. `result_o` only changes when a write occurs.
- R3: The flag bits are: bit 4 sign, bit 3 zero, bit 2 nibble carry, bit 1 parity, bit 0 carry. Whenever an operation updates them:
  - sign equals result bit 7;
  - zero is set only for an all-zero result;
  - parity is set when the result holds an even number of ones.
- R4: Add (code 0) and add-with-carry (code 1, adds `carry_in`) write A+B(+cin) mod 256 and update all five flags. Carry is the carry out of bit 7. Nibble carry is the carry out of bit 3.
- R5: Subtract (code 2) and subtract-with-borrow (code 3, subtracts `carry_in`) write A−B(−bin) mod 256 and update all five flags.
  - Carry is set when B plus the borrow exceeds A.
  - Nibble carry is the carry out of bit 3 of A + ~B + (1 − borrow).
- R6: Compare (code 9) updates the flags exactly as subtract without borrow, but `wr_en_o` stays 0 and `result_o` holds.
- R7: Increment (code 4) and decrement (code 5) write the second operand plus or minus one. They update sign, zero, nibble carry and parity, and leave carry unchanged.
  - Increment: nibble carry is set when the operand's low nibble is 0xF.
  - Decrement: nibble carry is set when the operand's low nibble is nonzero.
- R8: AND (code 6), OR (code 7) and XOR (code 8) update sign, zero and parity from the result and clear carry. Nibble carry is set by AND and cleared by OR and XOR.
- R9: Complement (code 10) writes the bitwise inverse of the accumulator and changes no flag.
- R10: The rotates write the accumulator rotated by one place and update only the carry flag:
  - code 11, left: carry and bit 0 take old bit 7;
  - code 12, right: carry and bit 7 take old bit 0;
  - code 13, left through carry: carry takes old bit 7, bit 0 takes `carry_in`;
  - code 14, right through carry: carry takes old bit 0, bit 7 takes `carry_in`.
- R11: Code 15 performs no write and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Enable strobe for one operation |
| op_code | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand (register or immediate) |
| carry_in | input | 1 | Incoming carry / borrow |
| result_o | output | 8 | Registered result |
| wr_en_o | output | 1 | Write-back enable for the result |
| flags_o | output | 5 | Flag register {sign, zero, nibble carry, parity, carry} |

## Verification
The bench builds the block with its defaults: an 8-bit datapath, a nibble boundary after bit 3, and the option that makes AND set the nibble carry. These values place the nibble-carry and borrow corners at operand values that can be reached directly, such as 0x0F+0x01, 0x00−0x01, 0xFF+0x01 and equal operands in compare. Directed sequences cover each operation with carry_in both set and clear. A long random run follows, with idle cycles mixed in, so that flag retention is tested across every ordering of operations that update different flag subsets.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_INC  = 4'd4,
      OP_DEC  = 4'd5,
      OP_AND  = 4'd6,
      OP_OR   = 4'd7,
      OP_XOR  = 4'd8,
      OP_CMP  = 4'd9,
      OP_NOT  = 4'd10,
      OP_ROL  = 4'd11,
      OP_ROR  = 4'd12,
      OP_ROLC = 4'd13,
      OP_RORC = 4'd14,
      OP_NOP  = 4'd15
   } alu_op_e;

   localparam int FLG_CY = 0;
   localparam int FLG_P  = 1;
   localparam int FLG_AC = 2;
   localparam int FLG_Z  = 3;
   localparam int FLG_S  = 4;
   localparam int FLG_N  = 5;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int W   = 8,
   parameter int NIB = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         nib_c,
   output logic         cy
);
   localparam int HI_W = W - NIB;

   logic [W-1:0]  b_eff;
   logic          c0;
   logic [NIB:0]  lo;
   logic [HI_W:0] hi;

   // subtraction as A + ~B + ~borrow
   assign b_eff = sub ? ~b : b;
   assign c0    = sub ^ cin;
   assign lo    = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c0};
   assign hi    = {1'b0, a[W-1:NIB]} + {1'b0, b_eff[W-1:NIB]} + {{HI_W{1'b0}}, lo[NIB]};
   assign sum   = {hi[HI_W-1:0], lo[NIB-1:0]};
   assign nib_c = lo[NIB];
   assign cy    = hi[HI_W] ^ sub;
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cy
);
   always_comb begin
      res = a;
      cy  = cin;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         OP_ROL:  begin res = {a[W-2:0], a[W-1]}; cy = a[W-1]; end
         OP_ROR:  begin res = {a[0], a[W-1:1]};   cy = a[0];   end
         OP_ROLC: begin res = {a[W-2:0], cin};    cy = a[W-1]; end
         OP_RORC: begin res = {cin, a[W-1:1]};    cy = a[0];   end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_flaggen.sv
module acc_alu_flaggen #(
   parameter int W = 8
) (
   input  logic [W-1:0] res,
   output logic         sign,
   output logic         zero,
   output logic         even
);
   assign sign = res[W-1];
   assign zero = (res == '0);
   assign even = ~(^res);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int NIB_BITS    = 4,
   parameter bit AND_SETS_AC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] opnd_in,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result_o,
   output logic             wr_en_o,
   output logic [4:0]       flags_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("acc_alu: WIDTH must be at least 2");
   end
   if (NIB_BITS < 1 || NIB_BITS >= WIDTH) begin : g_bad_nib
      $error("acc_alu: NIB_BITS must lie inside the word");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_code);

   logic [WIDTH-1:0] as_a, as_b, as_sum, lg_res;
   logic             as_cin, as_sub, as_nib, as_cy, lg_cy;
   logic             fg_s, fg_z, fg_p, and_ac;
   logic [WIDTH-1:0] nxt_res;
   logic [4:0]       calc_flg, upd_mask, nxt_flg;
   logic             nxt_wr, is_rot;

   always_comb begin
      as_a   = acc_in;
      as_b   = opnd_in;
      as_cin = 1'b0;
      as_sub = 1'b0;
      case (op)
         OP_ADC: as_cin = carry_in;
         OP_SUB, OP_CMP: as_sub = 1'b1;
         OP_SBB: begin as_sub = 1'b1; as_cin = carry_in; end
         OP_INC: begin as_a = opnd_in; as_b = '0; as_cin = 1'b1; end
         OP_DEC: begin as_a = opnd_in; as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
         default: ;
      endcase
   end

   acc_alu_addsub #(.W(WIDTH), .NIB(NIB_BITS)) u_addsub (
      .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
      .sum(as_sum), .nib_c(as_nib), .cy(as_cy)
   );

   acc_alu_logic #(.W(WIDTH)) u_logic (
      .op(op_code), .a(acc_in), .b(opnd_in), .cin(carry_in),
      .res(lg_res), .cy(lg_cy)
   );

   acc_alu_flaggen #(.W(WIDTH)) u_flaggen (
      .res(nxt_res), .sign(fg_s), .zero(fg_z), .even(fg_p)
   );

   if (AND_SETS_AC) begin : g_and_ac_set
      assign and_ac = 1'b1;
   end else begin : g_and_ac_clr
      assign and_ac = 1'b0;
   end

   assign is_rot = (op == OP_ROL) || (op == OP_ROR) || (op == OP_ROLC) || (op == OP_RORC);

   always_comb begin
      nxt_res  = lg_res;
      nxt_wr   = 1'b1;
      upd_mask = '0;
      calc_flg = '0;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            nxt_res  = as_sum;
            upd_mask = 5'b11111;
            calc_flg[FLG_AC] = as_nib;
            calc_flg[FLG_CY] = as_cy;
         end
         OP_CMP: begin
            nxt_res  = as_sum;
            nxt_wr   = 1'b0;
            upd_mask = 5'b11111;
            calc_flg[FLG_AC] = as_nib;
            calc_flg[FLG_CY] = as_cy;
         end
         OP_INC, OP_DEC: begin
            nxt_res  = as_sum;
            upd_mask = 5'b11110;
            calc_flg[FLG_AC] = as_nib;
         end
         OP_AND, OP_OR, OP_XOR: begin
            upd_mask = 5'b11111;
            calc_flg[FLG_AC] = (op == OP_AND) ? and_ac : 1'b0;
         end
         OP_ROL, OP_ROR, OP_ROLC, OP_RORC: begin
            upd_mask = 5'b00001;
            calc_flg[FLG_CY] = lg_cy;
         end
         OP_NOT: ;
         default: nxt_wr = 1'b0;
      endcase
      calc_flg[FLG_S] = fg_s;
      calc_flg[FLG_Z] = fg_z;
      calc_flg[FLG_P] = fg_p;
      nxt_flg = (upd_mask & calc_flg) | (~upd_mask & flags_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         wr_en_o  <= 1'b0;
         flags_o  <= '0;
      end else begin
         wr_en_o <= op_valid && nxt_wr;
         if (op_valid) begin
            flags_o <= nxt_flg;
            if (nxt_wr) result_o <= nxt_res;
         end
      end
   end

   // R2: an idle cycle leaves everything held and writes nothing
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!wr_en_o && $stable(flags_o) && $stable(result_o)));

   // R6: compare never requests a write
   assert_cmp_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CMP) |=> (!wr_en_o && $stable(result_o)));

   // R7: increment / decrement keep the carry bit
   assert_step_keeps_cy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == OP_INC || op == OP_DEC)) |=> $stable(flags_o[FLG_CY]));

   // R8: logical operations clear carry
   assert_logic_clears_cy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !flags_o[FLG_CY]);

   // R9: complement leaves the flags alone
   assert_not_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_NOT) |=> $stable(flags_o));

   // R10: rotates touch only the carry bit
   assert_rot_only_cy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_rot) |=> $stable(flags_o[FLG_S:FLG_P]));

   assert_rol_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_ROL) |=>
         (result_o == {$past(acc_in[WIDTH-2:0]), $past(acc_in[WIDTH-1])}));

   // R11: reserved code is a no-op
   assert_nop_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_NOP) |=> (!wr_en_o && $stable(flags_o)));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_code = 4'd0;
   logic [7:0] acc_in = 8'd0;
   logic [7:0] opnd_in = 8'd0;
   logic       carry_in = 1'b0;
   logic [7:0] result_o;
   logic       wr_en_o;
   logic [4:0] flags_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // model state
   int       m_res = 0;
   bit       m_wr = 1'b0;
   bit [4:0] m_flg = '0;
   string    m_req = "R1";

   always #10 clk = ~clk;

   acc_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
      .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
   );

   function automatic string req_of(int op);
      case (op)
         0, 1:    return "R4";
         2, 3:    return "R5";
         4, 5:    return "R7";
         6, 7, 8: return "R8";
         9:       return "R6";
         10:      return "R9";
         11, 12, 13, 14: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic compare_outputs();
      checks += 3;
      if (result_o !== m_res[7:0]) begin
         errors++;
         $display("FAIL %s result: actual %02h expected %02h", m_req, result_o, m_res[7:0]);
      end
      if (wr_en_o !== m_wr) begin
         errors++;
         $display("FAIL %s write enable: actual %0b expected %0b", m_req, wr_en_o, m_wr);
      end
      if (flags_o !== m_flg) begin
         errors++;
         $display("FAIL R3 %s flags: actual %05b expected %05b", m_req, flags_o, m_flg);
      end
   endtask

   // behavioural reference for one enabled operation
   task automatic model(int op, int a, int b, int c);
      int r = 0;
      int cy = m_flg[0];
      int ac = m_flg[2];
      bit wr = 1'b1;
      bit us = 1'b0, uz = 1'b0, uac = 1'b0, up = 1'b0, ucy = 1'b0;
      int bw;
      case (op)
         0, 1: begin
            bw = (op == 1) ? c : 0;
            r  = a + b + bw;
            cy = (r > 255);
            ac = ((a % 16) + (b % 16) + bw) >= 16;
            us = 1; uz = 1; uac = 1; up = 1; ucy = 1;
         end
         2, 3, 9: begin
            bw = (op == 3) ? c : 0;
            r  = a - b - bw;
            cy = (b + bw > a);
            ac = ((a % 16) + (15 - (b % 16)) + (1 - bw)) >= 16;
            wr = (op != 9);
            us = 1; uz = 1; uac = 1; up = 1; ucy = 1;
         end
         4: begin r = b + 1; ac = ((b % 16) == 15); us = 1; uz = 1; uac = 1; up = 1; end
         5: begin r = b - 1; ac = ((b % 16) != 0);  us = 1; uz = 1; uac = 1; up = 1; end
         6, 7, 8: begin
            if (op == 6) r = a & b;
            else if (op == 7) r = a | b;
            else r = a ^ b;
            ac = (op == 6); cy = 0;
            us = 1; uz = 1; uac = 1; up = 1; ucy = 1;
         end
         10: r = 255 - a;
         11: begin r = (a * 2) % 256 + a / 128; cy = a / 128; ucy = 1; end
         12: begin r = a / 2 + (a % 2) * 128;   cy = a % 2;   ucy = 1; end
         13: begin r = (a * 2) % 256 + c;       cy = a / 128; ucy = 1; end
         14: begin r = a / 2 + c * 128;         cy = a % 2;   ucy = 1; end
         default: wr = 1'b0;
      endcase
      r = ((r % 256) + 256) % 256;
      if (us)  m_flg[4] = (r >= 128);
      if (uz)  m_flg[3] = (r == 0);
      if (uac) m_flg[2] = ac[0];
      if (up)  m_flg[1] = ($countones(r[7:0]) % 2 == 0);
      if (ucy) m_flg[0] = cy[0];
      m_wr = wr;
      if (wr) m_res = r;
   endtask

   // one cycle: check the previous result, then drive the next input
   task automatic step(bit en, int op, int a, int b, int c);
      @(negedge clk);
      compare_outputs();
      op_valid = en;
      op_code  = op[3:0];
      acc_in   = a[7:0];
      opnd_in  = b[7:0];
      carry_in = c[0];
      if (en) begin
         m_req = req_of(op);
         model(op, a, b, c);
      end else begin
         m_req = "R2";
         m_wr  = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare_outputs();   // R1 reset state
      rst_n = 1'b1;
      m_req = "R1";
      // R4 add corners
      step(1, 0, 8'h0F, 8'h01, 0);
      step(1, 0, 8'hFF, 8'h01, 0);
      step(1, 1, 8'h7F, 8'h00, 1);
      step(1, 1, 8'hF0, 8'h0F, 1);
      // R5 subtract corners
      step(1, 2, 8'h00, 8'h01, 0);
      step(1, 2, 8'h35, 8'h35, 0);
      step(1, 3, 8'h10, 8'h0F, 1);
      step(1, 3, 8'h10, 8'h10, 1);
      // R6 compare
      step(1, 9, 8'h22, 8'h44, 0);
      step(1, 9, 8'h44, 8'h44, 1);
      // R7 increment/decrement keep carry
      step(1, 0, 8'hFF, 8'h02, 0);
      step(1, 4, 8'h00, 8'hFF, 0);
      step(1, 5, 8'h00, 8'h00, 0);
      step(1, 5, 8'h00, 8'h01, 0);
      step(1, 4, 8'h00, 8'h0E, 0);
      // R8 logic
      step(1, 6, 8'hF3, 8'h3C, 0);
      step(1, 7, 8'h00, 8'h00, 1);
      step(1, 8, 8'hA5, 8'h5A, 0);
      // R9 complement
      step(1, 0, 8'h80, 8'h80, 0);
      step(1, 10, 8'h5C, 8'h00, 1);
      // R10 rotates with both carry values
      for (int k = 11; k <= 14; k++) begin
         step(1, k, 8'h81, 8'h00, 0);
         step(1, k, 8'h42, 8'h00, 1);
      end
      // R11 reserved code, R2 idle
      step(1, 15, 8'h12, 8'h34, 1);
      step(0, 0, 8'hAA, 8'h55, 1);
      step(0, 2, 8'h00, 8'hFF, 0);
      // random run
      for (int i = 0; i < 3000; i++) begin
         step(($urandom_range(0, 9) != 0), $urandom_range(0, 15),
              $urandom_range(0, 255), $urandom_range(0, 255),
              ($urandom_range(0, 1) != 0) ? int'(m_flg[0]) : $urandom_range(0, 1));
      end
      @(negedge clk);
      compare_outputs();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule